// File: doc/BRIEF.md
# Debug-Halt Bus Timeout Enforcer

This block guarantees that a debugger can always take control of a core, even when a bus transaction never completes. When a debug halt has been requested while the load/store unit or the fetch unit still has bus traffic in flight, a timer starts. If the traffic drains and the core goes idle before the limit, the core enters debug halt on its own and the block does nothing. If the timer reaches the programmed limit first, the block pulses a termination strobe to every unit that still has traffic and raises a force-entry strobe. The core then enters debug halt without being fully quiesced.

Software programs an enable bit and a 5-bit exponent. The limit is two to the power of the exponent, in core clock cycles. A sticky loss register records, at the moment debug halt is entered, which units had traffic cut short. A debugger can read this register and write it to clear it. The counter is cleared when debug halt is left. It saturates instead of wrapping, and it is held at zero while the enable bit is clear.

Top module: `dbg_force_halt_unit`

## Requirements
- R1: The control register (csr_sel = 0) holds an enable at bit 0 and a threshold exponent at bits 5:1. It resets to all zeros, and its bits 31:6 always read 0.
- R2: The loss register (csr_sel = 1) holds the load/store flag at bit 1 and the fetch flag at bit 0. It resets to 0 and reads 0 above bit 1. A write loads bits 1:0. Without a write or a halt entry, the register holds its value, including across a halt exit.
- R3: With the enable bit set, the first rising edge that samples a pending halt request with any unit pending is edge 1. force_entry is then high for exactly the one cycle after edge 2^exponent.
- R4: At timeout, lsu_abort and ifu_abort pulse in that same cycle, and each unit's strobe fires only if that unit's pending flag is high.
- R5: While the enable bit is 0, no strobe is produced and the count is held at zero. Counting restarts from zero on the first edge after the enable bit becomes 1.
- R6: If the pending flags drop, and the core is idle, before the limit is reached, then no strobe fires and a halt entry leaves the loss register unchanged.
- R7: On halt_entered, each loss bit is set when its unit received a termination strobe during the current halt attempt.
- R8: halt_exited clears the count, so a later request again needs the full 2^exponent edges.
- R9: When a software write to the loss register falls in the same cycle as halt_entered, every bit that the entry latches ends up set.
- R10: Only one timeout strobe is produced per halt attempt, even if the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | 0 selects control, 1 selects loss register |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data of the selected register |
| dbg_halt_pending | input | 1 | A debug halt request is waiting |
| lsu_pending | input | 1 | Load/store bus transactions outstanding |
| ifu_pending | input | 1 | Fetch bus transactions outstanding |
| core_idle | input | 1 | Core is quiesced |
| halt_entered | input | 1 | One-cycle event: debug halt entered |
| halt_exited | input | 1 | One-cycle event: debug halt left |
| force_entry | output | 1 | One-cycle strobe: timeout reached, force entry |
| lsu_abort | output | 1 | One-cycle termination strobe to load/store unit |
| ifu_abort | output | 1 | One-cycle termination strobe to fetch unit |

## Verification
Two functions can land in the same cycle: a software write that clears the loss register, and the hardware latch on halt entry. The bench times a timeout on the load/store unit. In the entry cycle it drives a clear-all write together with halt_entered, then reads the register back. Bit 1 must have survived. A scoreboard predicts the exact cycle and unit mask of every strobe, so a strobe that repeats or fires late, early or on the wrong unit is also reported.

// File: rtl/fdh_pkg.sv
package fdh_pkg;
   localparam int unsigned UNIT_IFU  = 0;
   localparam int unsigned UNIT_LSU  = 1;
   localparam int unsigned NUM_UNITS = 2;
   localparam logic        SEL_CTRL  = 1'b0;
   localparam logic        SEL_STAT  = 1'b1;
endpackage

// File: rtl/fdh_ctrl_regs.sv
module fdh_ctrl_regs
   import fdh_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned EXP_W  = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 csr_we,
   input  logic                 csr_sel,
   input  logic [EXP_W:0]       csr_wbits,
   input  logic [NUM_UNITS-1:0] stat,
   output logic                 en,
   output logic [EXP_W-1:0]     expo,
   output logic [DATA_W-1:0]    csr_rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= 1'b0;
         expo <= '0;
      end else if (csr_we && (csr_sel == SEL_CTRL)) begin
         en   <= csr_wbits[0];
         expo <= csr_wbits[EXP_W:1];
      end
   end

   always_comb begin
      csr_rdata = '0;
      if (csr_sel == SEL_STAT) begin
         csr_rdata[NUM_UNITS-1:0] = stat;
      end else begin
         csr_rdata[0]       = en;
         csr_rdata[EXP_W:1] = expo;
      end
   end
endmodule

// File: rtl/fdh_timer.sv
module fdh_timer #(
   parameter int unsigned EXP_W = 5,
   parameter int unsigned CNT_W = 32,
   parameter int unsigned NU    = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           en,
   input  logic [EXP_W-1:0] expo,
   input  logic           req,
   input  logic [NU-1:0]  pend,
   input  logic           idle,
   input  logic           entered,
   input  logic           exited,
   output logic           fire,
   output logic [NU-1:0]  kill
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic             armed_q;
   logic             fired_q;
   logic             halted_q;
   logic             start;
   logic             count_now;

   assign limit     = {{(CNT_W-1){1'b0}}, 1'b1} << expo;
   assign start     = en && req && (|pend) && !halted_q;
   assign count_now = (armed_q || start) && !entered;
   assign fire      = en && armed_q && !fired_q && !idle && (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         armed_q  <= 1'b0;
         fired_q  <= 1'b0;
         halted_q <= 1'b0;
      end else begin
         if (entered) halted_q <= 1'b1;
         else if (exited) halted_q <= 1'b0;

         if (exited) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            fired_q <= 1'b0;
         end else if (!en) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
         end else begin
            if (entered) armed_q <= 1'b0;
            else if (start) armed_q <= 1'b1;
            if (count_now && (cnt_q != {CNT_W{1'b1}})) cnt_q <= cnt_q + 1'b1;
            if (fire) fired_q <= 1'b1;
         end
      end
   end

   for (genvar i = 0; i < NU; i++) begin : g_kill
      assign kill[i] = fire & pend[i];
   end
endmodule

// File: rtl/fdh_loss_latch.sv
module fdh_loss_latch #(
   parameter int unsigned NU = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NU-1:0] kill,
   input  logic          entered,
   input  logic          exited,
   input  logic          wr,
   input  logic [NU-1:0] wbits,
   output logic [NU-1:0] stat
);
   logic [NU-1:0] cut_q;
   logic [NU-1:0] stat_nxt;

   for (genvar i = 0; i < NU; i++) begin : g_unit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cut_q[i] <= 1'b0;
         else if (exited) cut_q[i] <= 1'b0;
         else if (kill[i]) cut_q[i] <= 1'b1;
      end
      always_comb begin
         stat_nxt[i] = wr ? wbits[i] : stat[i];
         if (entered && (cut_q[i] || kill[i])) stat_nxt[i] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= '0;
      else        stat <= stat_nxt;
   end
endmodule

// File: rtl/dbg_force_halt_unit.sv
module dbg_force_halt_unit
   import fdh_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned EXP_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic              csr_sel,
   input  logic [DATA_W-1:0] csr_wdata,
   output logic [DATA_W-1:0] csr_rdata,
   input  logic              dbg_halt_pending,
   input  logic              lsu_pending,
   input  logic              ifu_pending,
   input  logic              core_idle,
   input  logic              halt_entered,
   input  logic              halt_exited,
   output logic              force_entry,
   output logic              lsu_abort,
   output logic              ifu_abort
);
   localparam int unsigned CNT_W = 1 << EXP_W;

   if (EXP_W < 1 || EXP_W > 6) begin : g_bad_exp
      $error("EXP_W out of range");
   end
   if (DATA_W < EXP_W + 2 || DATA_W < NUM_UNITS) begin : g_bad_data
      $error("DATA_W too narrow for register fields");
   end

   logic                 en_w;
   logic [EXP_W-1:0]     expo_w;
   logic [NUM_UNITS-1:0] pend_w;
   logic [NUM_UNITS-1:0] kill_w;
   logic [NUM_UNITS-1:0] stat_w;
   logic                 stat_wr;
   logic                 unused_hi;

   assign pend_w[UNIT_IFU] = ifu_pending;
   assign pend_w[UNIT_LSU] = lsu_pending;
   assign stat_wr          = csr_we && (csr_sel == SEL_STAT);
   assign unused_hi        = ^csr_wdata[DATA_W-1:EXP_W+1];

   fdh_ctrl_regs #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .csr_we    (csr_we),
      .csr_sel   (csr_sel),
      .csr_wbits (csr_wdata[EXP_W:0]),
      .stat      (stat_w),
      .en        (en_w),
      .expo      (expo_w),
      .csr_rdata (csr_rdata)
   );

   fdh_timer #(.EXP_W(EXP_W), .CNT_W(CNT_W), .NU(NUM_UNITS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_w),
      .expo    (expo_w),
      .req     (dbg_halt_pending),
      .pend    (pend_w),
      .idle    (core_idle),
      .entered (halt_entered),
      .exited  (halt_exited),
      .fire    (force_entry),
      .kill    (kill_w)
   );

   fdh_loss_latch #(.NU(NUM_UNITS)) u_loss (
      .clk     (clk),
      .rst_n   (rst_n),
      .kill    (kill_w),
      .entered (halt_entered),
      .exited  (halt_exited),
      .wr      (stat_wr),
      .wbits   (csr_wdata[NUM_UNITS-1:0]),
      .stat    (stat_w)
   );

   assign lsu_abort = kill_w[UNIT_LSU];
   assign ifu_abort = kill_w[UNIT_IFU];
endmodule

// File: rtl/fdh_checker.sv
module fdh_checker
   import fdh_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned EXP_W  = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 csr_we,
   input logic                 csr_sel,
   input logic [DATA_W-1:0]    csr_rdata,
   input logic                 lsu_pending,
   input logic                 ifu_pending,
   input logic                 halt_entered,
   input logic                 halt_exited,
   input logic                 force_entry,
   input logic                 lsu_abort,
   input logic                 ifu_abort,
   input logic                 en_q,
   input logic [NUM_UNITS-1:0] stat_q
);
   p_ctrl_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_sel == SEL_CTRL) |-> (csr_rdata[DATA_W-1:EXP_W+1] == '0));

   p_stat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!(csr_we && csr_sel == SEL_STAT) && !halt_entered) |=> $stable(stat_q));

   p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      force_entry |=> !force_entry);

   p_abort_needs_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lsu_abort || ifu_abort) |-> force_entry);

   p_lsu_abort_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lsu_abort |-> lsu_pending);

   p_ifu_abort_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ifu_abort |-> ifu_pending);

   p_quiet_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !force_entry);

   p_exit_silences_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halt_exited |=> !force_entry);

   p_lsu_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_entered && lsu_abort) |=> stat_q[UNIT_LSU]);

   p_ifu_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_entered && ifu_abort) |=> stat_q[UNIT_IFU]);
endmodule

bind dbg_force_halt_unit fdh_checker #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .csr_we       (csr_we),
   .csr_sel      (csr_sel),
   .csr_rdata    (csr_rdata),
   .lsu_pending  (lsu_pending),
   .ifu_pending  (ifu_pending),
   .halt_entered (halt_entered),
   .halt_exited  (halt_exited),
   .force_entry  (force_entry),
   .lsu_abort    (lsu_abort),
   .ifu_abort    (ifu_abort),
   .en_q         (en_w),
   .stat_q       (stat_w)
);

// File: tb/tb_dbg_force_halt_unit.sv
module tb_dbg_force_halt_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic        csr_sel = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        dbg_halt_pending = 1'b0;
   logic        lsu_pending = 1'b0;
   logic        ifu_pending = 1'b0;
   logic        core_idle = 1'b0;
   logic        halt_entered = 1'b0;
   logic        halt_exited = 1'b0;
   logic        force_entry, lsu_abort, ifu_abort;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   typedef struct {
      int    at;
      bit    l;
      bit    f;
      string tag;
   } strobe_t;
   strobe_t sb[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dbg_force_halt_unit dut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .dbg_halt_pending(dbg_halt_pending), .lsu_pending(lsu_pending),
      .ifu_pending(ifu_pending), .core_idle(core_idle),
      .halt_entered(halt_entered), .halt_exited(halt_exited),
      .force_entry(force_entry), .lsu_abort(lsu_abort), .ifu_abort(ifu_abort)
   );

   task automatic step(int n = 1);
      repeat (n) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic csr_wr(logic sel, logic [31:0] d);
      csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
      step();
      csr_we = 1'b0; csr_wdata = '0;
   endtask

   task automatic rd_check(logic sel, logic [31:0] expv, string tag);
      csr_sel = sel;
      #1;
      checks++;
      if (csr_rdata !== expv) begin
         failures++;
         $display("FAIL %s: rdata sel=%0d actual=%h expected=%h", tag, sel, csr_rdata, expv);
      end
   endtask

   task automatic expect_strobe(int at, bit l, bit f, string tag);
      strobe_t it;
      it.at = at; it.l = l; it.f = f; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic pulse_enter();
      halt_entered = 1'b1; dbg_halt_pending = 1'b0;
      step();
      halt_entered = 1'b0;
   endtask

   task automatic pulse_exit();
      halt_exited = 1'b1;
      step();
      halt_exited = 1'b0;
   endtask

   // monitor: compare every strobe against the scoreboard head
   always @(negedge clk) begin
      if (rst_n && (force_entry || lsu_abort || ifu_abort)) begin
         checks++;
         if (sb.size() == 0) begin
            failures++;
            $display("FAIL R10: unexpected strobe at cycle %0d actual l=%0d f=%0d expected none",
                     cyc, lsu_abort, ifu_abort);
         end else begin
            strobe_t it;
            it = sb.pop_front();
            if (it.at != cyc || it.l != lsu_abort || it.f != ifu_abort || !force_entry) begin
               failures++;
               $display("FAIL %s: strobe actual cyc=%0d l=%0d f=%0d force=%0d expected cyc=%0d l=%0d f=%0d",
                        it.tag, cyc, lsu_abort, ifu_abort, force_entry, it.at, it.l, it.f);
            end
         end
      end
   end

   task automatic finish_run();
      checks++;
      if (sb.size() != 0) begin
         failures++;
         $display("FAIL %s: missing strobe actual none expected cyc=%0d", sb[0].tag, sb[0].at);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int p;
      step(3);
      rst_n = 1'b1;
      step();
      // R1, R2 reset values
      rd_check(1'b0, 32'h0, "R1 reset");
      rd_check(1'b1, 32'h0, "R2 reset");
      // R1 upper bits read zero
      csr_wr(1'b0, 32'hFFFF_FFFF);
      rd_check(1'b0, 32'h0000_003F, "R1 field mask");

      // R3/R10: exponent 2, load/store only, request held long
      csr_wr(1'b0, (32'd2 << 1) | 32'd1);
      p = cyc;
      lsu_pending = 1'b1; dbg_halt_pending = 1'b1;
      expect_strobe(p + 4, 1'b1, 1'b0, "R3");
      step(9); // R10: no second strobe while still pending
      pulse_enter();
      rd_check(1'b1, 32'h2, "R7 lsu latched");
      lsu_pending = 1'b0;
      pulse_exit();
      step(2);
      rd_check(1'b1, 32'h2, "R2 sticky across exit");
      csr_wr(1'b1, 32'h0);
      rd_check(1'b1, 32'h0, "R2 clear by write");

      // R4: exponent 0, both units
      csr_wr(1'b0, 32'd1);
      p = cyc;
      lsu_pending = 1'b1; ifu_pending = 1'b1; dbg_halt_pending = 1'b1;
      expect_strobe(p + 1, 1'b1, 1'b1, "R4 both");
      step(4);
      pulse_enter();
      rd_check(1'b1, 32'h3, "R7 both latched");
      lsu_pending = 1'b0; ifu_pending = 1'b0;
      pulse_exit();
      csr_wr(1'b1, 32'h0);

      // R6: traffic drains before the limit of 16
      csr_wr(1'b0, (32'd4 << 1) | 32'd1);
      lsu_pending = 1'b1; ifu_pending = 1'b1; dbg_halt_pending = 1'b1;
      step(5);
      lsu_pending = 1'b0; ifu_pending = 1'b0; core_idle = 1'b1;
      step(2);
      pulse_enter();
      step(25);
      rd_check(1'b1, 32'h0, "R6 clean entry");
      pulse_exit();
      core_idle = 1'b0;

      // R5: disabled, then enabled with exponent 1 while request held
      csr_wr(1'b0, 32'h0);
      lsu_pending = 1'b1; dbg_halt_pending = 1'b1;
      step(12);
      rd_check(1'b1, 32'h0, "R5 disabled no loss");
      p = cyc;
      expect_strobe(p + 3, 1'b1, 1'b0, "R5 count from enable");
      csr_wr(1'b0, (32'd1 << 1) | 32'd1);
      step(6);
      pulse_enter();
      rd_check(1'b1, 32'h2, "R7 after enable");
      lsu_pending = 1'b0;
      pulse_exit();
      csr_wr(1'b1, 32'h0);

      // R8: partial count, exit, then full window again (exponent 3)
      csr_wr(1'b0, (32'd3 << 1) | 32'd1);
      ifu_pending = 1'b1; dbg_halt_pending = 1'b1;
      step(5);
      pulse_enter();
      rd_check(1'b1, 32'h0, "R8 entry before limit");
      pulse_exit();
      p = cyc;
      dbg_halt_pending = 1'b1;
      expect_strobe(p + 8, 1'b0, 1'b1, "R8 full window after exit");
      step(12);
      pulse_enter();
      rd_check(1'b1, 32'h1, "R7 ifu latched");
      ifu_pending = 1'b0;
      pulse_exit();
      csr_wr(1'b1, 32'h0);

      // R9: clearing write in the same cycle as entry
      csr_wr(1'b0, 32'd1);
      p = cyc;
      lsu_pending = 1'b1; dbg_halt_pending = 1'b1;
      expect_strobe(p + 1, 1'b1, 1'b0, "R9 strobe");
      step(3);
      csr_we = 1'b1; csr_sel = 1'b1; csr_wdata = 32'h0;
      pulse_enter();
      csr_we = 1'b0;
      rd_check(1'b1, 32'h2, "R9 entry wins over write");
      lsu_pending = 1'b0;
      pulse_exit();

      step(4);
      finish_run();
   end
endmodule